// File: doc/BRIEF.md
# Control Register Write Unit

This block stores a processor's architectural control registers: a control word at index 0, a fault-address register at index 2, a translation-root register at index 3, a feature-enable register at index 4, and a 4-bit task-priority view at index 8. A single operation code selects one action per cycle. The actions are a numbered read, a numbered write, a machine-status-word load that merges four low bits into the control word, a timestamp read, a performance-counter read, and a load of the timestamp offset.

Index 8 goes to one of two places. When virtual-interrupt mode is off, writes go out through a priority write strobe and reads come back from an external priority input. A 4-bit virtual priority copy is updated on every index-8 write, and it serves reads while virtual-interrupt mode is on. Privileged timestamp and counter reads are checked against two enable bits in register 4 and the current privilege level. A permitted timestamp read returns the free-running count plus the stored offset, split into two halves.

Top module: `cru_top`

## Requirements
- R1: After synchronous reset, all stored registers read 0. This covers indices 0, 2, 3 and 4, the virtual priority, and the timestamp offset.
- R2: A write to index 0, 2, 3 or 4 stores the full data word on the next rising clock edge. A read of that index returns the stored word combinationally. `rd_data` is 0 whenever the operation is not a read.
- R3: A read of any index other than 0, 2, 3, 4 and 8 returns 0. A write to such an index changes no stored register.
- R4: A status-word load (op 3) sets index 0 to (old AND NOT 0xE) OR (data AND 0xF). Bits above 3 keep their old values.
- R5: A status-word load never clears bit 0 of index 0 once that bit is 1.
- R6: A write to index 8 sets the virtual priority to data bits 3:0 in every mode. `ext_prio_we` is 1 during that write only when `vint_mode` is 0, and `ext_prio_wdata` then equals data bits 3:0.
- R7: A read of index 8 returns `ext_prio`, zero-extended, when `vint_mode` is 0. When `vint_mode` is 1 it returns the virtual priority.
- R8: A timestamp read (op 4) raises `fault_gp` when bit 2 of index 4 is 1 and `cpl` is not 0. A faulting read drives `tsc_lo` and `tsc_hi` to 0. Otherwise these outputs carry the low and high halves of `tsc_count` plus the offset.
- R9: A counter read (op 5) raises `fault_gp` when bit 8 of index 4 is 1 and `cpl` is not 0. In every other case it raises `fault_ud`. The two faults are never active together.
- R10: Op 6 loads the timestamp offset from the data word on the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | 0 idle, 1 read, 2 write, 3 status-word load, 4 timestamp read, 5 counter read, 6 offset load |
| reg_idx | input | 4 | Register index for read and write |
| wr_data | input | XLEN | Write, status-word or offset data |
| cpl | input | 2 | Current privilege level |
| vint_mode | input | 1 | Virtual-interrupt mode |
| ext_prio | input | 4 | External task-priority value |
| tsc_count | input | TSC_W | Free-running timestamp count |
| rd_data | output | XLEN | Read result |
| ext_prio_we | output | 1 | External priority write strobe |
| ext_prio_wdata | output | 4 | External priority write value |
| fault_gp | output | 1 | Protection fault |
| fault_ud | output | 1 | Illegal-operation fault |
| tsc_lo | output | TSC_W/2 | Timestamp low half |
| tsc_hi | output | TSC_W/2 | Timestamp high half |

## Verification
The register path is exercised with a table of write/read-back pairs. The table mixes full-width patterns on the stored indices, index 8, and several unimplemented indices, which separates true storage from the index-8 path and from zero-filled holes. Status-word loads are applied to a control word whose bit 0 is first set and then clear. This tells the merge mask apart from a plain low-nibble overwrite and from a rule that lets bit 0 drop. Index 8 is driven in both interrupt modes, and timestamp and counter reads are swept over privilege levels and enable bits. A carry across the 32-bit boundary in the offset sum confirms how the result is split into halves.

// File: rtl/cru_pkg.sv
package cru_pkg;

    localparam int IDX_W     = 4;
    localparam int PRIO_W    = 4;
    localparam int OP_W      = 3;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int MSW_W     = 4;
    localparam int TSD_BIT   = 2;
    localparam int PCE_BIT   = 8;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE    = 3'd0,
        OP_READ    = 3'd1,
        OP_WRITE   = 3'd2,
        OP_MSW     = 3'd3,
        OP_RDTSC   = 3'd4,
        OP_RDPMC   = 3'd5,
        OP_SET_OFS = 3'd6
    } cru_op_e;

    localparam logic [IDX_W-1:0] IDX_CTL  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_FADR = 4'd2;
    localparam logic [IDX_W-1:0] IDX_ROOT = 4'd3;
    localparam logic [IDX_W-1:0] IDX_FEAT = 4'd4;
    localparam logic [IDX_W-1:0] IDX_PRIO = 4'd8;

    typedef struct packed {
        logic              rd;
        logic              wr_slot;
        logic [SLOT_W-1:0] slot;
        logic              wr_prio;
        logic              msw;
        logic              set_ofs;
        logic              rd_tsc;
        logic              rd_pmc;
    } cru_cmd_t;

    function automatic logic is_slot(input logic [IDX_W-1:0] idx);
        return (idx == IDX_CTL) || (idx == IDX_FADR) ||
               (idx == IDX_ROOT) || (idx == IDX_FEAT);
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [IDX_W-1:0] idx);
        logic [SLOT_W-1:0] s;
        case (idx)
            IDX_FADR: s = SLOT_W'(1);
            IDX_ROOT: s = SLOT_W'(2);
            IDX_FEAT: s = SLOT_W'(3);
            default:  s = SLOT_W'(0);
        endcase
        return s;
    endfunction

    function automatic logic is_known(input logic [IDX_W-1:0] idx);
        return is_slot(idx) || (idx == IDX_PRIO);
    endfunction

endpackage

// File: rtl/cru_decode.sv
module cru_decode
    import cru_pkg::*;
(
    input  logic [OP_W-1:0]  op_code,
    input  logic [IDX_W-1:0] reg_idx,
    output cru_cmd_t         cmd
);
    cru_op_e op;

    always_comb begin
        op          = cru_op_e'(op_code);
        cmd         = '0;
        cmd.rd      = (op == OP_READ);
        cmd.wr_slot = (op == OP_WRITE) && is_slot(reg_idx);
        cmd.slot    = slot_of(reg_idx);
        cmd.wr_prio = (op == OP_WRITE) && (reg_idx == IDX_PRIO);
        cmd.msw     = (op == OP_MSW);
        cmd.set_ofs = (op == OP_SET_OFS);
        cmd.rd_tsc  = (op == OP_RDTSC);
        cmd.rd_pmc  = (op == OP_RDPMC);
    end
endmodule

// File: rtl/cru_regfile.sv
module cru_regfile
    import cru_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_slot,
    input  logic [SLOT_W-1:0]                 slot,
    input  logic                              msw,
    input  logic [XLEN-1:0]                   wdata,
    output logic [NUM_SLOTS-1:0][XLEN-1:0]    slot_q
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic hit;
        assign hit = wr_slot && (int'(slot) == g);

        if (g == 0) begin : g_ctl
            logic [XLEN-1:0] merged;
            // low nibble merge: bits 3:1 follow data, bit 0 can only rise
            assign merged = {slot_q[g][XLEN-1:MSW_W],
                             wdata[MSW_W-1:1],
                             slot_q[g][0] | wdata[0]};
            always_ff @(posedge clk) begin
                if (rst)
                    slot_q[g] <= '0;
                else if (msw)
                    slot_q[g] <= merged;
                else if (hit)
                    slot_q[g] <= wdata;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    slot_q[g] <= '0;
                else if (hit)
                    slot_q[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/cru_prio_route.sv
module cru_prio_route
    import cru_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_prio,
    input  logic [PRIO_W-1:0] wdata,
    input  logic              vint_mode,
    input  logic [PRIO_W-1:0] ext_prio,
    output logic              ext_we,
    output logic [PRIO_W-1:0] ext_wdata,
    output logic [PRIO_W-1:0] prio_rd,
    output logic [PRIO_W-1:0] vprio_q
);
    always_ff @(posedge clk) begin
        if (rst)
            vprio_q <= '0;
        else if (wr_prio)
            vprio_q <= wdata;
    end

    assign ext_we    = wr_prio && !vint_mode;
    assign ext_wdata = wdata;
    assign prio_rd   = vint_mode ? vprio_q : ext_prio;
endmodule

// File: rtl/cru_perm_check.sv
module cru_perm_check #(
    parameter int XLEN  = 64,
    parameter int TSC_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_ofs,
    input  logic [XLEN-1:0]    wdata,
    input  logic               rd_tsc,
    input  logic               rd_pmc,
    input  logic               tsd_en,
    input  logic               pce_en,
    input  logic               cpl_nz,
    input  logic [TSC_W-1:0]   tsc_count,
    output logic               fault_gp,
    output logic               fault_ud,
    output logic [TSC_W/2-1:0] tsc_lo,
    output logic [TSC_W/2-1:0] tsc_hi
);
    localparam int HALF = TSC_W / 2;

    logic [TSC_W-1:0] ofs_q;
    logic [TSC_W-1:0] stamp;
    logic             tsc_gp;
    logic             pmc_gp;

    always_ff @(posedge clk) begin
        if (rst)
            ofs_q <= '0;
        else if (set_ofs)
            ofs_q <= TSC_W'(wdata);
    end

    always_comb begin
        tsc_gp   = rd_tsc && tsd_en && cpl_nz;
        pmc_gp   = rd_pmc && pce_en && cpl_nz;
        fault_gp = tsc_gp || pmc_gp;
        fault_ud = rd_pmc && !pmc_gp;
        stamp    = tsc_count + ofs_q;
        if (rd_tsc && !tsc_gp) begin
            tsc_lo = stamp[HALF-1:0];
            tsc_hi = stamp[TSC_W-1:HALF];
        end else begin
            tsc_lo = '0;
            tsc_hi = '0;
        end
    end
endmodule

// File: rtl/cru_top.sv
module cru_top
    import cru_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int TSC_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         op_code,
    input  logic [3:0]         reg_idx,
    input  logic [XLEN-1:0]    wr_data,
    input  logic [1:0]         cpl,
    input  logic               vint_mode,
    input  logic [3:0]         ext_prio,
    input  logic [TSC_W-1:0]   tsc_count,
    output logic [XLEN-1:0]    rd_data,
    output logic               ext_prio_we,
    output logic [3:0]         ext_prio_wdata,
    output logic               fault_gp,
    output logic               fault_ud,
    output logic [TSC_W/2-1:0] tsc_lo,
    output logic [TSC_W/2-1:0] tsc_hi
);
    cru_cmd_t                         cmd;
    logic [NUM_SLOTS-1:0][XLEN-1:0]   slot_q;
    logic [PRIO_W-1:0]                prio_rd;
    logic [PRIO_W-1:0]                vprio_q;
    logic [XLEN-1:0]                  feat_q;

    cru_decode u_dec (
        .op_code (op_code),
        .reg_idx (reg_idx),
        .cmd     (cmd)
    );

    cru_regfile #(.XLEN(XLEN)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_slot (cmd.wr_slot),
        .slot    (cmd.slot),
        .msw     (cmd.msw),
        .wdata   (wr_data),
        .slot_q  (slot_q)
    );

    cru_prio_route u_prio (
        .clk       (clk),
        .rst       (rst),
        .wr_prio   (cmd.wr_prio),
        .wdata     (wr_data[PRIO_W-1:0]),
        .vint_mode (vint_mode),
        .ext_prio  (ext_prio),
        .ext_we    (ext_prio_we),
        .ext_wdata (ext_prio_wdata),
        .prio_rd   (prio_rd),
        .vprio_q   (vprio_q)
    );

    assign feat_q = slot_q[slot_of(IDX_FEAT)];

    cru_perm_check #(.XLEN(XLEN), .TSC_W(TSC_W)) u_perm (
        .clk       (clk),
        .rst       (rst),
        .set_ofs   (cmd.set_ofs),
        .wdata     (wr_data),
        .rd_tsc    (cmd.rd_tsc),
        .rd_pmc    (cmd.rd_pmc),
        .tsd_en    (feat_q[TSD_BIT]),
        .pce_en    (feat_q[PCE_BIT]),
        .cpl_nz    (cpl != 2'd0),
        .tsc_count (tsc_count),
        .fault_gp  (fault_gp),
        .fault_ud  (fault_ud),
        .tsc_lo    (tsc_lo),
        .tsc_hi    (tsc_hi)
    );

    always_comb begin
        rd_data = '0;
        if (cmd.rd) begin
            if (is_slot(reg_idx))
                rd_data = slot_q[cmd.slot];
            else if (reg_idx == IDX_PRIO)
                rd_data = XLEN'(prio_rd);
        end
    end
endmodule

// File: rtl/cru_checker.sv
module cru_checker
    import cru_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int TSC_W = 64
) (
    input logic                            clk,
    input logic                            rst,
    input logic [2:0]                      op_code,
    input logic [3:0]                      reg_idx,
    input logic [XLEN-1:0]                 wr_data,
    input logic                            fault_gp,
    input logic                            fault_ud,
    input logic [TSC_W/2-1:0]              tsc_lo,
    input logic [TSC_W/2-1:0]              tsc_hi,
    input logic [NUM_SLOTS-1:0][XLEN-1:0]  slot_q,
    input logic [PRIO_W-1:0]               vprio_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (slot_q == '0 && vprio_q == '0)); // R1

    AST_MSW_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_MSW) |=> (slot_q[0][XLEN-1:MSW_W] == $past(slot_q[0][XLEN-1:MSW_W]))); // R4

    AST_PE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_MSW && slot_q[0][0]) |=> slot_q[0][0]); // R5

    AST_VPRIO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_WRITE && reg_idx == IDX_PRIO) |=> (vprio_q == $past(wr_data[PRIO_W-1:0]))); // R6

    AST_HOLE_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_WRITE && !is_known(reg_idx)) |=> ($stable(slot_q) && $stable(vprio_q))); // R3

    AST_TSC_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_RDTSC && fault_gp) |-> (tsc_lo == '0 && tsc_hi == '0)); // R8

    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(fault_gp && fault_ud)); // R9
endmodule

bind cru_top cru_checker #(.XLEN(XLEN), .TSC_W(TSC_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .op_code  (op_code),
    .reg_idx  (reg_idx),
    .wr_data  (wr_data),
    .fault_gp (fault_gp),
    .fault_ud (fault_ud),
    .tsc_lo   (tsc_lo),
    .tsc_hi   (tsc_hi),
    .slot_q   (slot_q),
    .vprio_q  (vprio_q)
);

// File: tb/cru_top_tb_top.sv
module cru_top_tb_top;
    localparam int XLEN  = 64;
    localparam int TSC_W = 64;
    localparam int NVEC  = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [2:0]         op_code = 3'd0;
    logic [3:0]         reg_idx = 4'd0;
    logic [XLEN-1:0]    wr_data = '0;
    logic [1:0]         cpl = 2'd0;
    logic               vint_mode = 1'b1;
    logic [3:0]         ext_prio = 4'd0;
    logic [TSC_W-1:0]   tsc_count = '0;
    logic [XLEN-1:0]    rd_data;
    logic               ext_prio_we;
    logic [3:0]         ext_prio_wdata;
    logic               fault_gp;
    logic               fault_ud;
    logic [TSC_W/2-1:0] tsc_lo;
    logic [TSC_W/2-1:0] tsc_hi;

    int checks = 0;
    int failures = 0;
    logic       seen_we;
    logic [3:0] seen_wd;

    always #2 clk = ~clk;

    cru_top #(.XLEN(XLEN), .TSC_W(TSC_W)) dut_i (
        .clk(clk), .rst(rst), .op_code(op_code), .reg_idx(reg_idx),
        .wr_data(wr_data), .cpl(cpl), .vint_mode(vint_mode),
        .ext_prio(ext_prio), .tsc_count(tsc_count), .rd_data(rd_data),
        .ext_prio_we(ext_prio_we), .ext_prio_wdata(ext_prio_wdata),
        .fault_gp(fault_gp), .fault_ud(fault_ud), .tsc_lo(tsc_lo), .tsc_hi(tsc_hi)
    );

    typedef struct packed {
        logic [3:0]  idx;
        logic [63:0] data;
        logic [63:0] exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  64'h8000_0000_0000_0011, 64'h8000_0000_0000_0011},
        '{4'd2,  64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0},
        '{4'd3,  64'hFFFF_FFFF_FFFF_F000, 64'hFFFF_FFFF_FFFF_F000},
        '{4'd4,  64'h0000_0000_0000_06F0, 64'h0000_0000_0000_06F0},
        '{4'd8,  64'h0000_0000_0000_00A7, 64'h0000_0000_0000_0007},
        '{4'd5,  64'h0000_0000_0000_DEAD, 64'h0},
        '{4'd15, 64'h0000_0000_0000_BEEF, 64'h0},
        '{4'd1,  64'h0000_0000_0000_0055, 64'h0}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [3:0] idx, input logic [63:0] d);
        @(negedge clk);
        op_code = op; reg_idx = idx; wr_data = d;
        #1;
        seen_we = ext_prio_we;
        seen_wd = ext_prio_wdata;
        @(negedge clk);
        op_code = 3'd0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [63:0] v);
        @(negedge clk);
        op_code = 3'd1; reg_idx = idx;
        #1;
        v = rd_data;
        op_code = 3'd0;
    endtask

    task automatic probe(input logic [2:0] op);
        @(negedge clk);
        op_code = op;
        #1;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(4'd0, v); check("R1 idx0", v, 64'h0);
        rd(4'd2, v); check("R1 idx2", v, 64'h0);
        rd(4'd3, v); check("R1 idx3", v, 64'h0);
        rd(4'd4, v); check("R1 idx4", v, 64'h0);
        rd(4'd8, v); check("R1 vprio", v, 64'h0);
        probe(3'd4); check("R1 offset", {tsc_hi, tsc_lo}, 64'h0);
        op_code = 3'd0;
        probe(3'd2); check("R2 rd_data idle", rd_data, 64'h0);
        op_code = 3'd0;

        // table walk: write, then read back
        for (int i = 0; i < NVEC; i++) begin
            do_op(3'd2, VECS[i].idx, VECS[i].data);
            rd(VECS[i].idx, v);
            if (VECS[i].idx == 4'd8)
                check("R6 vprio readback", v, VECS[i].exp);
            else if (VECS[i].exp == VECS[i].data)
                check("R2 store readback", v, VECS[i].exp);
            else
                check("R3 hole reads zero", v, VECS[i].exp);
        end

        // R3: hole writes left stored values alone
        rd(4'd2, v); check("R3 idx2 intact", v, 64'h1234_5678_9ABC_DEF0);
        rd(4'd3, v); check("R3 idx3 intact", v, 64'hFFFF_FFFF_FFFF_F000);
        rd(4'd8, v); check("R3 vprio intact", v, 64'h7);

        // R4/R5 status-word load
        do_op(3'd3, 4'd0, 64'hFFFF_FFFF_FFFF_FFF0);
        rd(4'd0, v); check("R4 upper kept, low zero", v, 64'h8000_0000_0000_0011);
        do_op(3'd3, 4'd0, 64'h0000_0000_0000_000A);
        rd(4'd0, v); check("R4 merge 0xA", v, 64'h8000_0000_0000_001B);
        do_op(3'd2, 4'd0, 64'h0000_0000_0000_0040);
        do_op(3'd3, 4'd0, 64'h0000_0000_0000_0005);
        rd(4'd0, v); check("R4 merge 0x5", v, 64'h0000_0000_0000_0045);
        do_op(3'd3, 4'd0, 64'h0000_0000_0000_0000);
        rd(4'd0, v); check("R5 bit0 sticky", v, 64'h0000_0000_0000_0041);

        // R6/R7 priority routing
        vint_mode = 1'b0; ext_prio = 4'h9;
        do_op(3'd2, 4'd8, 64'h3C);
        check("R6 strobe vint off", {63'd0, seen_we}, 64'h1);
        check("R6 strobe data", {60'd0, seen_wd}, 64'hC);
        rd(4'd8, v); check("R7 ext read", v, 64'h9);
        vint_mode = 1'b1;
        rd(4'd8, v); check("R7 virtual read", v, 64'hC);
        do_op(3'd2, 4'd8, 64'h25);
        check("R6 no strobe vint on", {63'd0, seen_we}, 64'h0);
        rd(4'd8, v); check("R6 vprio vint on", v, 64'h5);

        // R10/R8 timestamp
        do_op(3'd6, 4'd0, 64'h20);
        tsc_count = 64'h0000_0001_FFFF_FFF0; cpl = 2'd3;
        probe(3'd4);
        check("R10 offset sum lo", {32'd0, tsc_lo}, 64'h10);
        check("R10 offset sum hi", {32'd0, tsc_hi}, 64'h2);
        check("R8 no fault tsd clear", {63'd0, fault_gp}, 64'h0);
        op_code = 3'd0;
        do_op(3'd2, 4'd4, 64'h4);
        probe(3'd4);
        check("R8 fault cpl3", {63'd0, fault_gp}, 64'h1);
        check("R8 zero on fault", {tsc_hi, tsc_lo}, 64'h0);
        cpl = 2'd0; #1;
        check("R8 no fault cpl0", {63'd0, fault_gp}, 64'h0);
        check("R8 value cpl0", {tsc_hi, tsc_lo}, 64'h0000_0002_0000_0010);
        op_code = 3'd0;

        // R9 counter read
        cpl = 2'd3;
        probe(3'd5);
        check("R9 ud pce clear", {62'd0, fault_gp, fault_ud}, 64'h1);
        op_code = 3'd0;
        do_op(3'd2, 4'd4, 64'h104);
        cpl = 2'd1;
        probe(3'd5);
        check("R9 gp pce set", {62'd0, fault_gp, fault_ud}, 64'h2);
        cpl = 2'd0; #1;
        check("R9 ud cpl0", {62'd0, fault_gp, fault_ud}, 64'h1);
        op_code = 3'd0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule